// File: doc/BRIEF.md
# Clock-Factor Asynchronous Serial Receiver

This block takes in serial characters on one input line, timed by a receive clock. The receive clock runs at 1, 16 or 64 times the bit rate, and a two-bit factor input selects which. A second two-bit input sets the character length to 5, 6, 7 or 8 data bits. In each frame a low start bit comes first, then the data bits with the least significant bit first, then one stop bit.

In the 16x and 64x modes the receiver finds the falling edge of the start bit and waits half a bit cell. It then checks that the line is still low, which rejects short glitches. After that it samples one bit per full bit period. In the 1x mode the line is assumed to be already synchronised to the receive clock, and one bit is taken on every rising edge. When the stop bit has been sampled, the receiver presents the character right-aligned on a parallel output and gives a one-cycle ready strobe. A framing-error flag goes with the strobe when the stop bit reads low. Factor code 00 is reserved and holds the receiver idle.

Top module: `prog_rx`

## Requirements
- R1: The factor code 00 holds the receiver idle. No ready strobe is produced while it is applied, whatever the line does.
- R2: Factor code 01 (1x) treats the edge that first sees the line low as the start bit. The data bits are taken on the next consecutive rising edges, and the stop bit on the edge after the last data bit.
- R3: Factor code 10 (16x) checks the start bit on the 9th rising edge, counting the edge that first sees the line low as edge 1. Every later bit is sampled 16 edges after the one before it.
- R4: Factor code 11 (64x) checks the start bit on the 33rd rising edge, counting the same way. Every later bit is sampled 64 edges after the one before it.
- R5: In the 16x and 64x modes, a start bit that reads high at its check sample is discarded. No strobe follows, and the receiver is ready for the next falling edge.
- R6: The first data bit received lands in bit 0 of `data_o`, and each later bit lands in the next higher position.
- R7: Length code 00/01/10/11 gives 5/6/7/8 data bits. Bits of `data_o` above the character length read 0.
- R8: `valid_o` is high for exactly one cycle for each character received.
- R9: `frame_err_o` is high together with `valid_o` when the stop bit sampled low, and low otherwise.
- R10: `valid_o`, `data_o` and `frame_err_o` update on the clock edge that samples the stop bit. With a factor of F and a length of N bits, the stop bit is taken on edge 1 + F/2 + F·(N+1), where F/2 is 0 for 1x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock; all sampling on rising edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| factor_i | input | 2 | Clock factor: 00 idle, 01 1x, 10 16x, 11 64x |
| len_i | input | 2 | Character length: 00 5, 01 6, 10 7, 11 8 bits |
| rxd_i | input | 1 | Serial data line, idle high |
| data_o | output | DATA_W | Received character, right-aligned, upper bits zero |
| valid_o | output | 1 | One-cycle character-ready strobe |
| frame_err_o | output | 1 | Stop bit read low; valid with `valid_o` |

## Verification
The bench builds the block with its default parameters: 8-bit characters and divide values of 16 and 64. These defaults bring all four factor codes and all four length codes within reach. For each frame the bench counts edges from the first low level to the strobe. That count pins the exact sample point in every mode. Glitches that end before the half-cell check, low stop bits, and frames sent while the factor is 00 are each driven and checked at the outputs.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    FAC_SYNC = 2'b00,
    FAC_X1   = 2'b01,
    FAC_X16  = 2'b10,
    FAC_X64  = 2'b11
  } fac_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_st_e;
endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import rx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  localparam int CNT_W  = $clog2(DIV_HI)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] factor_i,
  input  logic       load_i,
  input  logic       run_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q, half_m1, full_m1;

  always_comb begin
    unique case (fac_e'(factor_i))
      FAC_X16: begin
        half_m1 = CNT_W'(DIV_MID / 2 - 1);
        full_m1 = CNT_W'(DIV_MID - 1);
      end
      FAC_X64: begin
        half_m1 = CNT_W'(DIV_HI / 2 - 1);
        full_m1 = CNT_W'(DIV_HI - 1);
      end
      default: begin
        half_m1 = '0;
        full_m1 = '0;
      end
    endcase
  end

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= half_m1;
    else if (run_i) begin
      if (cnt_q == '0)    cnt_q <= full_m1;
      else                cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [1:0]        len_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sr_q;
  logic [1:0]        sh;

  // bits enter at the top, so a short character sits high until aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (clear_i)  sr_q <= '0;
    else if (shift_i)  sr_q <= {bit_i, sr_q[DATA_W-1:1]};
  end

  assign sh     = 2'd3 - len_i;
  assign data_o = sr_q >> sh;
endmodule

// File: rtl/prog_rx.sv
module prog_rx
  import rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        factor_i,
  input  logic [1:0]        len_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int LEN_BASE = DATA_W - 3;

  rx_st_e            st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic              enabled, load, run, tick, shift, done;
  logic [DATA_W-1:0] shr_data, data_q;
  logic              valid_q, ferr_q;

  assign enabled  = fac_e'(factor_i) != FAC_SYNC;
  assign last_idx = IDX_W'(LEN_BASE - 1) + IDX_W'(len_i);
  assign run      = enabled && (st_q != ST_IDLE);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    load  = 1'b0;
    shift = 1'b0;
    done  = 1'b0;
    if (!enabled) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!rxd_i) begin
          load  = 1'b1;
          idx_d = '0;
          st_d  = (fac_e'(factor_i) == FAC_X1) ? ST_DATA : ST_START;
        end
        ST_START: if (tick) st_d = rxd_i ? ST_IDLE : ST_DATA;
        ST_DATA: if (tick) begin
          shift = 1'b1;
          if (idx_q == last_idx) st_d = ST_STOP;
          else                   idx_d = idx_q + 1'b1;
        end
        ST_STOP: if (tick) begin
          done = 1'b1;
          st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      valid_q <= done;
      ferr_q  <= done && !rxd_i;
      if (done) data_q <= shr_data;
    end
  end

  rx_bit_timer #(
    .DIV_MID(DIV_MID),
    .DIV_HI (DIV_HI)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .factor_i(factor_i),
    .load_i  (load),
    .run_i   (run),
    .tick_o  (tick)
  );

  rx_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .shift_i(shift),
    .bit_i  (rxd_i),
    .len_i  (len_i),
    .data_o (shr_data)
  );

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign frame_err_o = ferr_q;
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        factor_i,
  input logic [1:0]        len_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              frame_err_o
);
  logic [3:0] n_bits;
  assign n_bits = 4'(DATA_W - 3) + 4'(len_i);

  a_r1_sync_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (factor_i == 2'b00) |=> !valid_o);

  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> n_bits) == '0));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_err_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o);
endmodule

bind prog_rx rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .factor_i   (factor_i),
  .len_i      (len_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .frame_err_o(frame_err_o)
);

// File: tb/sim_prog_rx.sv
`timescale 1ns/1ps
module sim_prog_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] factor = 2'b10;
  logic [1:0] len = 2'b11;
  logic       rxd = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, frame_err_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  prog_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .factor_i(factor), .len_i(len),
    .rxd_i(rxd), .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // line level for edge j (1-based from first low level)
  function automatic logic line_at(input int j, input int div, input int n,
                                   input logic [7:0] val, input bit stop_b,
                                   input bit glitch);
    int c = (j - 1) / div;
    int o = (j - 1) % div;
    if (glitch) return (c == 0 && o < 4) ? 1'b0 : 1'b1;
    if (c == 0) return 1'b0;
    if (c <= n) return val[c-1];
    if (c == n + 1) return stop_b;
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [1:0] fac, input logic [1:0] ln,
                           input logic [7:0] val, input bit stop_b,
                           input bit glitch, input bit expect_none,
                           input string req);
    int div = (fac == 2'b01) ? 1 : (fac == 2'b11) ? 64 : 16;
    int n = 5 + int'(ln);
    int e_exp = 1 + div / 2 + div * (n + 1);
    int limit = e_exp + 2 * div + 8;
    int vcnt = 0, first = 0;
    logic [7:0] got_d = '0, exp_d;
    logic got_f = 1'b0;
    exp_d = val & 8'((1 << n) - 1);
    @(negedge clk);
    factor = fac;
    len = ln;
    rxd = line_at(1, div, n, val, stop_b, glitch);
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (valid_o) begin
        vcnt++;
        if (vcnt == 1) begin
          first = k; got_d = data_o; got_f = frame_err_o;
        end
      end
      rxd = line_at(k + 1, div, n, val, stop_b, glitch);
    end
    rxd = 1'b1;
    if (expect_none) begin
      chk(vcnt == 0, req, "strobe count", vcnt, 0);
    end else begin
      chk(first == e_exp, {req, " R10"}, "stop sample edge", first, e_exp);
      chk(got_d == exp_d, {req, " R6 R7"}, "data", got_d, exp_d);
      chk(got_f == !stop_b, "R9", "frame error", got_f, !stop_b);
      chk(vcnt == 1, "R8", "strobe count", vcnt, 1);
    end
  endtask

  task automatic t_reset;
    chk(valid_o == 1'b0, "R8", "reset valid", valid_o, 0);
    chk(frame_err_o == 1'b0, "R9", "reset ferr", frame_err_o, 0);
    chk(data_o == 8'h00, "R6", "reset data", data_o, 0);
  endtask

  task automatic t_x1;
    run_frame(2'b01, 2'b11, 8'hA5, 1'b1, 1'b0, 1'b0, "R2");
    run_frame(2'b01, 2'b00, 8'hF3, 1'b1, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_x16;
    run_frame(2'b10, 2'b11, 8'h3C, 1'b1, 1'b0, 1'b0, "R3");
    run_frame(2'b10, 2'b10, 8'hC1, 1'b1, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_x64;
    run_frame(2'b11, 2'b11, 8'h81, 1'b1, 1'b0, 1'b0, "R4");
    run_frame(2'b11, 2'b01, 8'hED, 1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_lengths;
    for (int l = 0; l < 4; l++)
      run_frame(2'b10, 2'(l), 8'hFF, 1'b1, 1'b0, 1'b0, "R7");
    run_frame(2'b01, 2'b11, 8'h01, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_glitch;
    run_frame(2'b10, 2'b11, 8'h00, 1'b1, 1'b1, 1'b1, "R5");
    run_frame(2'b11, 2'b11, 8'h00, 1'b1, 1'b1, 1'b1, "R5");
    run_frame(2'b10, 2'b11, 8'h5A, 1'b1, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_ferr;
    run_frame(2'b10, 2'b11, 8'h96, 1'b0, 1'b0, 1'b0, "R9");
    run_frame(2'b01, 2'b01, 8'h2B, 1'b0, 1'b0, 1'b0, "R9");
    run_frame(2'b10, 2'b11, 8'h4E, 1'b1, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_sync_idle;
    run_frame(2'b00, 2'b11, 8'h00, 1'b0, 1'b0, 1'b1, "R1");
    run_frame(2'b00, 2'b00, 8'hAA, 1'b1, 1'b0, 1'b1, "R1");
    run_frame(2'b10, 2'b11, 8'h77, 1'b1, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_x1();
    t_x16();
    t_x64();
    t_lengths();
    t_glitch();
    t_ferr();
    t_sync_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule